// File: doc/BRIEF.md
# Single-Datum DMA Transfer Sequencer

This block carries out one DMA transfer of a single datum for a channel that an external arbiter has already picked. On an accepted start it reads the datum from the source address into an internal holding register, then writes that register to the destination address. Each bus phase holds its strobe until the memory side returns ready.

A start is accepted only when the global enable and the channel's enable are set, and the channel's end flag, the non-maskable-interrupt flag and the sticky address-error flag are all clear. A start that does not meet these conditions is dropped. An address is treated as faulty when it is not aligned to the transfer size. A faulty source turns both phases into one-clock idle cycles. A faulty destination still lets the read run, but the write becomes an idle cycle.

Every accepted transfer ends with a one-cycle done pulse and an error indicator. An address error also sets the sticky flag, and that flag blocks every channel until software clears it. Software clears the flag by reading it as 1 and then writing 0.

Top module: `dma_xfer_seq`

## Requirements
- R1: An accepted transfer with both addresses aligned asserts bus_rd with bus_addr equal to the source, captures bus_rdata on the ready cycle, then asserts bus_wr with bus_addr equal to the destination and bus_wdata equal to the captured datum. It ends with done=1 and err=0. bus_rd and bus_wr are never asserted together.
- R2: When the source is misaligned, neither bus_rd nor bus_wr is asserted. Each phase lasts exactly one clock, so done rises two clocks after the accepting edge, with err=1.
- R3: When only the destination is misaligned, the read phase runs normally, bus_wr is never asserted, the write phase lasts one clock, and done rises with err=1.
- R4: Alignment depends on the size code xsize. 0 (byte) is always aligned. 1 (halfword) needs address bit 0 to be 0. 2 and 3 (word) need address bits 1:0 to be 00.
- R5: A start in the idle state is accepted only when master_en=1, ch_en[start_ch]=1, ch_end[start_ch]=0, nmi_flag=0 and ae_flag=0. Any other start is ignored: busy stays 0, no strobe is asserted and no done is issued. A start while busy is also ignored.
- R6: A transfer that ends with err=1 sets ae_flag, which reads 1 from the cycle after the done pulse.
- R7: ae_flag is sticky. A stat_wr with stat_wdata=0 clears it only if a stat_rd saw ae_flag=1 after the previous stat_wr. Any stat_wr uses up that read. Writing 1 never changes the flag.
- R8: While a bus strobe is asserted without bus_rdy, the strobe, bus_addr and bus_wdata stay unchanged in the next cycle.
- R9: done is a one-cycle pulse. busy is 1 from the cycle after the accepting edge through the done cycle. With read wait Wr and write wait Ww cycles, done arrives 2+Wr+Ww clocks after acceptance, counting only the phases that run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Transfer request |
| start_ch | input | CW | Granted channel index |
| src_addr | input | AW | Source address |
| dst_addr | input | AW | Destination address |
| xsize | input | 2 | Size code: 0 byte, 1 halfword, 2/3 word |
| master_en | input | 1 | Global transfer enable |
| ch_en | input | NCH | Per-channel enable |
| ch_end | input | NCH | Per-channel end flag |
| nmi_flag | input | 1 | Global NMI flag |
| stat_rd | input | 1 | Status read strobe (arms the clear) |
| stat_wr | input | 1 | Status write strobe |
| stat_wdata | input | 1 | Value written to the error flag |
| ae_flag | output | 1 | Sticky address-error flag |
| bus_rd | output | 1 | Read strobe |
| bus_wr | output | 1 | Write strobe |
| bus_addr | output | AW | Bus address |
| bus_wdata | output | DW | Write data |
| bus_rdata | input | DW | Read data |
| bus_rdy | input | 1 | Phase completion handshake |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | End-of-transfer pulse |
| err | output | 1 | Address error on this transfer (valid with done) |

## Verification
The assertions assume that bus_rdy is raised only while a strobe is asserted. They also assume that status reads and writes do not fall in the same cycle as a done pulse with an error. The bench drives ready only in cycles where it sees a strobe, with a random wait of zero to three cycles. It issues status accesses only after a transfer has finished. Random sizes and addresses are biased so that aligned, source-faulty and destination-faulty transfers all occur. Permission is tested with directed starts that fail one condition at a time.

// File: rtl/dma_xfer_seq.sv
module dma_xfer_seq #(
  parameter int NCH = 8,
  parameter int AW  = 32,
  parameter int DW  = 32,
  parameter int CW  = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [CW-1:0] start_ch,
  input  logic [AW-1:0] src_addr,
  input  logic [AW-1:0] dst_addr,
  input  logic [1:0]    xsize,
  input  logic          master_en,
  input  logic [NCH-1:0] ch_en,
  input  logic [NCH-1:0] ch_end,
  input  logic          nmi_flag,
  input  logic          stat_rd,
  input  logic          stat_wr,
  input  logic          stat_wdata,
  output logic          ae_flag,
  output logic          bus_rd,
  output logic          bus_wr,
  output logic [AW-1:0] bus_addr,
  output logic [DW-1:0] bus_wdata,
  input  logic [DW-1:0] bus_rdata,
  input  logic          bus_rdy,
  output logic          busy,
  output logic          done,
  output logic          err
);

  typedef enum logic [1:0] {S_IDLE, S_READ, S_WRITE, S_DONE} st_t;

  st_t           state;
  logic [AW-1:0] src_q, dst_q;
  logic [1:0]    size_q;
  logic [DW-1:0] hold_q;
  logic          sbad_q, dbad_q, arm_q;
  logic          can_go, accept;

  function automatic logic misal(input logic [AW-1:0] a, input logic [1:0] sz);
    case (sz)
      2'd0:    misal = 1'b0;
      2'd1:    misal = a[0];
      default: misal = |a[1:0];
    endcase
  endfunction

  assign can_go = master_en & ch_en[start_ch] & ~ch_end[start_ch] & ~nmi_flag & ~ae_flag;
  assign accept = (state == S_IDLE) & start & can_go;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      src_q  <= '0;
      dst_q  <= '0;
      size_q <= '0;
      hold_q <= '0;
      sbad_q <= 1'b0;
      dbad_q <= 1'b0;
    end else begin
      case (state)
        S_IDLE: if (accept) begin
          state  <= S_READ;
          src_q  <= src_addr;
          dst_q  <= dst_addr;
          size_q <= xsize;
          sbad_q <= misal(src_addr, xsize);
          dbad_q <= misal(dst_addr, xsize);
        end
        S_READ: begin
          if (sbad_q) state <= S_WRITE;
          else if (bus_rdy) begin
            hold_q <= bus_rdata;
            state  <= S_WRITE;
          end
        end
        S_WRITE: if (sbad_q | dbad_q | bus_rdy) state <= S_DONE;
        default: state <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ae_flag <= 1'b0;
      arm_q   <= 1'b0;
    end else if (state == S_DONE && (sbad_q | dbad_q)) begin
      ae_flag <= 1'b1;
    end else if (stat_wr) begin
      if (arm_q && !stat_wdata) ae_flag <= 1'b0;
      arm_q <= 1'b0;
    end else if (stat_rd && ae_flag) begin
      arm_q <= 1'b1;
    end
  end

  assign bus_rd    = (state == S_READ) & ~sbad_q;
  assign bus_wr    = (state == S_WRITE) & ~sbad_q & ~dbad_q;
  assign bus_addr  = (state == S_WRITE) ? dst_q : src_q;
  assign bus_wdata = hold_q;
  assign busy      = (state != S_IDLE);
  assign done      = (state == S_DONE);
  assign err       = done & (sbad_q | dbad_q);

endmodule

module dma_xfer_seq_chk #(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          master_en,
  input logic          busy,
  input logic          bus_rd,
  input logic          bus_wr,
  input logic          bus_rdy,
  input logic [AW-1:0] bus_addr,
  input logic [DW-1:0] bus_wdata,
  input logic [1:0]    size_q,
  input logic          done,
  input logic          err,
  input logic          ae_flag,
  input logic          stat_wr,
  input logic          stat_wdata
);

  // R1
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n) !(bus_rd && bus_wr));

  // R4
  rd_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd |-> (size_q == 2'd0) || (size_q == 2'd1 && !bus_addr[0]) || (bus_addr[1:0] == 2'b00));

  // R5
  gate_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start && !master_en) |=> !busy);

  // R6
  err_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && err) |=> ae_flag);

  // R7
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ae_flag && !(stat_wr && !stat_wdata)) |=> ae_flag);

  // R8
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && !bus_rdy) |=> (bus_rd && $stable(bus_addr)));

  // R8
  wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && !bus_rdy) |=> (bus_wr && $stable(bus_addr) && $stable(bus_wdata)));

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);

endmodule

bind dma_xfer_seq dma_xfer_seq_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .master_en(master_en), .busy(busy),
  .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_rdy(bus_rdy), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .size_q(size_q), .done(done), .err(err),
  .ae_flag(ae_flag), .stat_wr(stat_wr), .stat_wdata(stat_wdata)
);

// File: tb/sim_dma_xfer_seq.sv
module sim_dma_xfer_seq;
  localparam int NCH = 8, AW = 32, DW = 32, CW = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 0; logic [CW-1:0] start_ch = 0;
  logic [AW-1:0] src_addr = 0, dst_addr = 0; logic [1:0] xsize = 0;
  logic master_en = 1; logic [NCH-1:0] ch_en = '1, ch_end = '0;
  logic nmi_flag = 0, stat_rd = 0, stat_wr = 0, stat_wdata = 0;
  logic ae_flag, bus_rd, bus_wr, busy, done, err;
  logic [AW-1:0] bus_addr; logic [DW-1:0] bus_wdata, bus_rdata = 0;
  logic bus_rdy = 0;
  int checks = 0, fails = 0, cyc_cnt = 0;

  always #2 clk = ~clk;

  dma_xfer_seq #(.NCH(NCH), .AW(AW), .DW(DW)) u0 (.*);

  function automatic bit bad(input logic [AW-1:0] a, input logic [1:0] sz);
    return (sz == 0) ? 1'b0 : (sz == 1) ? a[0] : (a[1:0] != 0);
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc_cnt++;
    if (cyc_cnt > 100000) begin
      fails++; checks++;
      $display("FAIL watchdog actual=%0d expected=<100000", cyc_cnt);
      report();
    end
  end

  task automatic xfer(input logic [AW-1:0] s, input logic [AW-1:0] d, input logic [1:0] sz,
                      input logic [CW-1:0] c, input logic [DW-1:0] rv, input int wr, input int ww);
    bit sb, db; int rc, wc, nrd, nwr, dcyc; logic [AW-1:0] wa; logic [DW-1:0] wd; logic e;
    sb = bad(s, sz); db = bad(d, sz);
    rc = 0; wc = 0; nrd = 0; nwr = 0; dcyc = -1; e = 0; wa = 0; wd = 0;
    start = 1; start_ch = c; src_addr = s; dst_addr = d; xsize = sz;
    @(negedge clk); start = 0;
    chk("R9 busy after accept", busy, 1);
    for (int k = 0; k < 40; k++) begin
      bus_rdy = 0;
      if (done) begin dcyc = k; e = err; break; end
      chk("R1 strobes exclusive", bus_rd & bus_wr, 0);
      if (bus_rd) begin
        if (rc == wr) begin bus_rdy = 1; bus_rdata = rv; nrd++;
          chk("R1 read address", bus_addr, s); end
        else rc++;
      end
      if (bus_wr) begin
        if (wc == ww) begin bus_rdy = 1; nwr++; wa = bus_addr; wd = bus_wdata; end
        else wc++;
      end
      @(negedge clk);
    end
    bus_rdy = 0;
    chk(sb ? "R2 read suppressed" : "R3 read performed", nrd, sb ? 0 : 1);
    chk((sb || db) ? "R3 write suppressed" : "R1 write performed", nwr, (sb || db) ? 0 : 1);
    if (!sb && !db) begin
      chk("R1 write address", wa, d);
      chk("R1 write data", wd, rv);
    end
    chk("R9 done timing", dcyc, 2 + (sb ? 0 : wr) + ((sb || db) ? 0 : ww));
    chk("R2 R3 err", e, sb || db);
    @(negedge clk);
    chk("R9 done pulse", done, 0);
    chk("R6 flag after error", ae_flag, sb || db);
  endtask

  task automatic sw_rd(); stat_rd = 1; @(negedge clk); stat_rd = 0; endtask
  task automatic sw_wr(input logic v); stat_wr = 1; stat_wdata = v; @(negedge clk); stat_wr = 0; endtask

  task automatic clear_ae();
    sw_rd(); sw_wr(0);
    chk("R7 clear after read", ae_flag, 0);
  endtask

  task automatic reject(input string req);
    int seen = 0;
    start = 1; start_ch = 3; src_addr = 32'h100; dst_addr = 32'h200; xsize = 2;
    @(negedge clk); start = 0;
    for (int k = 0; k < 4; k++) begin
      seen |= busy | bus_rd | bus_wr | done;
      @(negedge clk);
    end
    chk(req, seen, 0);
  endtask

  initial begin
    void'($urandom(32'd17));
    @(negedge clk); @(negedge clk);
    chk("R5 reset idle", {busy, done, bus_rd, bus_wr, ae_flag}, 0);
    rst_n = 1;
    @(negedge clk);

    xfer(32'h1000, 32'h2000, 2, 0, 32'hCAFE_F00D, 0, 0);
    xfer(32'h1004, 32'h2008, 2, 5, 32'h1234_5678, 3, 2);
    xfer(32'h1001, 32'h2003, 0, 7, 32'hA5, 1, 1);
    // R4 halfword boundary
    xfer(32'h1002, 32'h2006, 1, 2, 32'hBEEF, 0, 1);
    // R2 faulty source
    xfer(32'h1002, 32'h2000, 2, 1, 32'h0, 2, 2);
    // R5 blocked while flag set
    reject("R5 blocked by ae_flag");
    // R7 sequences
    sw_wr(0); chk("R7 write0 without read", ae_flag, 1);
    sw_rd(); sw_wr(1); chk("R7 write1 ignored", ae_flag, 1);
    sw_wr(0); chk("R7 read consumed by write", ae_flag, 1);
    clear_ae();
    // R3 faulty destination
    xfer(32'h1000, 32'h2001, 1, 4, 32'h55, 2, 3);
    clear_ae();
    // R4 size 3 treated as word
    xfer(32'h1000, 32'h2002, 3, 4, 32'h66, 0, 0);
    clear_ae();

    master_en = 0; reject("R5 master disabled"); master_en = 1;
    ch_en[3] = 0; reject("R5 channel disabled"); ch_en[3] = 1;
    ch_end[3] = 1; reject("R5 channel end set"); ch_end[3] = 0;
    nmi_flag = 1; reject("R5 nmi set"); nmi_flag = 0;

    // R5 start while busy ignored
    start = 1; start_ch = 0; src_addr = 32'h40; dst_addr = 32'h80; xsize = 2;
    @(negedge clk); start_ch = 1; src_addr = 32'h41;
    @(negedge clk); start = 0; bus_rdy = 1; bus_rdata = 32'h9;
    chk("R5 busy start ignored addr", bus_addr, 32'h40);
    @(negedge clk); bus_rdy = 1;
    @(negedge clk); bus_rdy = 0;
    chk("R5 busy start ignored err", {done, err}, 2'b10);
    for (int k = 0; k < 4; k++) @(negedge clk);
    chk("R5 no second transfer", busy, 0);

    for (int n = 0; n < 60; n++) begin
      logic [AW-1:0] s, d; logic [1:0] sz;
      s = $urandom; d = $urandom; sz = 2'($urandom % 4);
      if ($urandom % 3 != 0) s[1:0] = 0;
      if ($urandom % 3 != 0) d[1:0] = 0;
      xfer(s, d, sz, CW'($urandom % NCH), $urandom, int'($urandom % 4), int'($urandom % 4));
      if (ae_flag) clear_ae();
    end
    report();
  end
endmodule